// File: doc/BRIEF.md
# Bus-Activity Restarted Watchdog

This block is a supervisory timer for a processor whose only sign of life is traffic on a two-wire serial bus. Rather than a dedicated kick strobe, it watches the clock and data lines directly. A bus start condition followed by a bus stop condition counts as one restart and clears the timeout counter. The counter advances on a slow timebase tick, nominally one per millisecond. When it reaches the selected period without a restart, the block raises a single-cycle timeout pulse, which a downstream reset generator stretches into a system reset.

The period comes from a 2-bit select: three lengths, or off. A write-protect input freezes the select, so the period cannot be changed while protection is on. Both bus lines pass through multi-flop synchronizers before edge detection. Any effective change of the select restarts the count from zero.

Top module: `twb_watchdog`

## Requirements
- R1: With the select held, the timeout pulse is high in the clock cycle after the tick that completes the period. Code 2'b00 gives P0 ticks (default 200), 2'b01 gives P1 ticks (default 600) and 2'b10 gives P2 ticks (default 1400), counted from the last clear.
- R2: Select code 2'b11 turns the timer off: the counter stays at zero and no timeout pulse is produced, however many ticks arrive.
- R3: A restart is a start (SDA falls while SCL stays high) followed later by a stop (SDA rises while SCL stays high). It clears the counter, so the next timeout needs a full period of further ticks.
- R4: A start that has not yet been followed by a stop does not clear the counter.
- R5: A stop with no start pending does not clear the counter. SDA changes while SCL is low are neither starts nor stops.
- R6: A second start before the stop keeps the detector armed, and the stop that follows still counts as a restart.
- R7: After a timeout the counter restarts from zero, so with no restarts a pulse recurs every period. Each pulse lasts exactly one clock cycle.
- R8: While wp_i is high, changes on per_sel_i are ignored: the period and the count carry on unchanged.
- R9: A select change accepted while wp_i is low clears the counter.
- R10: During and right after reset, timeout_o is low, the counter is zero and the select is DEFAULT_SEL.
- R11: The counter moves only on cycles where tick_i is high. Without ticks, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| arst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line, asynchronous to clk_i |
| sda_i | input | 1 | Serial data line, asynchronous to clk_i |
| tick_i | input | 1 | One-cycle timebase tick (nominally 1 ms) |
| per_sel_i | input | 2 | Period select: 00 short, 01 mid, 10 long, 11 off |
| wp_i | input | 1 | Write protect; when high the period select is frozen |
| timeout_o | output | 1 | One-cycle pulse when the period expires |

## Verification
The checker assumes that tick_i and per_sel_i are clean single-clock-domain signals, and that the selected period is at least two ticks, so two timeouts can never fall in adjacent cycles. It also assumes that each bus level is held long enough to pass the synchronizers. The bench drives the bus lines at negative edges and holds each level for several cycles. It never issues a tick while a bus condition or a select change is still travelling through the pipeline. This keeps every expected timeout at a tick count the requirements fix exactly.

// File: rtl/twb_pkg.sv
package twb_pkg;

   typedef enum logic [1:0] {
      PER_SHORT = 2'b00,
      PER_MID   = 2'b01,
      PER_LONG  = 2'b10,
      PER_OFF   = 2'b11
   } per_sel_e;

   typedef struct packed {
      logic scl;
      logic sda;
   } bus_t;

   localparam bus_t BUS_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
   parameter int          W       = 2,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk_i,
   input  logic         arst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni) stg[0] <= RST_VAL;
            else          stg[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni) stg[i] <= RST_VAL;
            else          stg[i] <= stg[i-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
   import twb_pkg::*;
(
   input  logic clk_i,
   input  logic arst_ni,
   input  bus_t bus_i,
   output logic kick_o,
   output logic armed_o
);

   bus_t bus_q;
   logic start_c, stop_c;
   logic armed_q, kick_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) bus_q <= BUS_IDLE;
      else          bus_q <= bus_i;
   end

   // SCL must be high on both samples for SDA movement to be a condition
   assign start_c = bus_q.scl && bus_i.scl &&  bus_q.sda && !bus_i.sda;
   assign stop_c  = bus_q.scl && bus_i.scl && !bus_q.sda &&  bus_i.sda;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         armed_q <= 1'b0;
         kick_q  <= 1'b0;
      end else begin
         kick_q <= stop_c && armed_q;
         if (stop_c)       armed_q <= 1'b0;
         else if (start_c) armed_q <= 1'b1;
      end
   end

   assign kick_o  = kick_q;
   assign armed_o = armed_q;

endmodule

// File: rtl/twb_period_counter.sv
module twb_period_counter
   import twb_pkg::*;
#(
   parameter int   P0          = 200,
   parameter int   P1          = 600,
   parameter int   P2          = 1400,
   parameter logic [1:0] DEFAULT_SEL = 2'b00,
   localparam int  CNT_W       = $clog2(P2)
) (
   input  logic             clk_i,
   input  logic             arst_ni,
   input  logic             tick_i,
   input  logic             kick_i,
   input  logic [1:0]       sel_i,
   input  logic             wp_i,
   output logic             timeout_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [1:0]       sel_o
);

   logic [1:0]       sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_c;
   logic             chg_c, off_c, to_q;

   assign chg_c = !wp_i && (sel_i != sel_q);
   assign off_c = (per_sel_e'(sel_q) == PER_OFF);

   always_comb begin
      unique case (per_sel_e'(sel_q))
         PER_SHORT: last_c = CNT_W'(P0 - 1);
         PER_MID:   last_c = CNT_W'(P1 - 1);
         PER_LONG:  last_c = CNT_W'(P2 - 1);
         default:   last_c = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)   sel_q <= DEFAULT_SEL;
      else if (chg_c) sel_q <= sel_i;
   end

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         cnt_q <= '0;
         to_q  <= 1'b0;
      end else if (chg_c || kick_i || off_c) begin
         cnt_q <= '0;
         to_q  <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q == last_c) begin
            cnt_q <= '0;
            to_q  <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            to_q  <= 1'b0;
         end
      end else begin
         to_q <= 1'b0;
      end
   end

   assign timeout_o = to_q;
   assign cnt_o     = cnt_q;
   assign sel_o     = sel_q;

endmodule

// File: rtl/twb_watchdog.sv
module twb_watchdog
   import twb_pkg::*;
#(
   parameter int   P0          = 200,
   parameter int   P1          = 600,
   parameter int   P2          = 1400,
   parameter int   SYNC_STAGES = 2,
   parameter logic [1:0] DEFAULT_SEL = 2'b00
) (
   input  logic       clk_i,
   input  logic       arst_ni,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       tick_i,
   input  logic [1:0] per_sel_i,
   input  logic       wp_i,
   output logic       timeout_o
);

   localparam int CNT_W = $clog2(P2);

   if (P0 < 2 || P1 <= P0 || P2 <= P1) begin : g_bad_periods
      $error("twb_watchdog: periods must satisfy 2 <= P0 < P1 < P2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twb_watchdog: SYNC_STAGES must be at least 2");
   end

   bus_t             bus_raw, bus_s;
   logic             kick, armed;
   logic [CNT_W-1:0] cnt;
   logic [1:0]       held_sel;

   assign bus_raw = '{scl: scl_i, sda: sda_i};

   twb_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_IDLE)
   ) u_sync (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .d_i     (bus_raw),
      .q_o     (bus_s)
   );

   twb_cond_detect u_det (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .bus_i   (bus_s),
      .kick_o  (kick),
      .armed_o (armed)
   );

   twb_period_counter #(
      .P0          (P0),
      .P1          (P1),
      .P2          (P2),
      .DEFAULT_SEL (DEFAULT_SEL)
   ) u_cnt (
      .clk_i     (clk_i),
      .arst_ni   (arst_ni),
      .tick_i    (tick_i),
      .kick_i    (kick),
      .sel_i     (per_sel_i),
      .wp_i      (wp_i),
      .timeout_o (timeout_o),
      .cnt_o     (cnt),
      .sel_o     (held_sel)
   );

endmodule

// File: rtl/twb_watchdog_chk.sv
module twb_watchdog_chk #(
   parameter int CNT_W = 8,
   parameter int P2    = 140
) (
   input logic             clk_i,
   input logic             arst_ni,
   input logic             tick_i,
   input logic             wp_i,
   input logic             timeout_o,
   input logic             kick,
   input logic             armed,
   input logic [CNT_W-1:0] cnt,
   input logic [1:0]       held_sel
);

   // R11: a timeout only follows a tick
   a_r11_to_after_tick: assert property (@(posedge clk_i) disable iff (!arst_ni)
      timeout_o |-> $past(tick_i));

   // R2: off code never yields a timeout and keeps the count at zero
   a_r2_off_silent: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (held_sel == 2'b11) |=> (!timeout_o && cnt == '0));

   // R8: the held select is frozen while write protect is high
   a_r8_wp_freezes: assert property (@(posedge clk_i) disable iff (!arst_ni)
      wp_i |=> $stable(held_sel));

   // R7: timeout pulses are one cycle wide
   a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!arst_ni)
      timeout_o |=> !timeout_o);

   // R3: a restart leaves the counter at zero
   a_r3_kick_clears: assert property (@(posedge clk_i) disable iff (!arst_ni)
      kick |=> (cnt == '0 && !timeout_o));

   // R5: a restart needs a pending start
   a_r5_kick_needs_arm: assert property (@(posedge clk_i) disable iff (!arst_ni)
      kick |-> $past(armed));

   // R1: the count never reaches the longest period
   a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!arst_ni)
      int'(cnt) < P2);

endmodule

bind twb_watchdog twb_watchdog_chk #(
   .CNT_W (CNT_W),
   .P2    (P2)
) u_chk (
   .clk_i     (clk_i),
   .arst_ni   (arst_ni),
   .tick_i    (tick_i),
   .wp_i      (wp_i),
   .timeout_o (timeout_o),
   .kick      (kick),
   .armed     (armed),
   .cnt       (cnt),
   .held_sel  (held_sel)
);

// File: tb/test_twb_watchdog.sv
`timescale 1ns/1ps
module test_twb_watchdog;

   localparam int P0 = 20;
   localparam int P1 = 60;
   localparam int P2 = 140;

   typedef struct {
      bit    exp;
      string req;
   } item_t;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1, tick = 1'b0, wp = 1'b0;
   logic [1:0] sel = 2'b00;
   logic       to;

   item_t q[$];
   int    n_chk = 0, n_bad = 0;
   int    mcnt = 0;
   logic [1:0] msel = 2'b00;
   bit    run = 1'b0;

   always #2.5 clk = ~clk;

   twb_watchdog #(.P0(P0), .P1(P1), .P2(P2)) i_twb_watchdog (
      .clk_i     (clk),
      .arst_ni   (arst_n),
      .scl_i     (scl),
      .sda_i     (sda),
      .tick_i    (tick),
      .per_sel_i (sel),
      .wp_i      (wp),
      .timeout_o (to)
   );

   function automatic int per_of(logic [1:0] s);
      case (s)
         2'b00:   return P0;
         2'b01:   return P1;
         2'b10:   return P2;
         default: return 0;
      endcase
   endfunction

   // monitor: compare the pulse one edge after each tick
   always @(posedge clk) begin
      logic t;
      item_t it;
      t = tick;
      #1;
      if (run) begin
         if (t) begin
            n_chk++;
            if (q.size() == 0) begin
               n_bad++;
               $display("FAIL %s: tick with empty scoreboard, actual %0b expected -", "R11", to);
            end else begin
               it = q.pop_front();
               if (to !== it.exp) begin
                  n_bad++;
                  $display("FAIL %s: timeout actual %0b expected %0b", it.req, to, it.exp);
               end
            end
         end else if (to !== 1'b0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11: pulse without tick, actual %0b expected 0", to);
         end
      end
   end

   task automatic tick_once(string req);
      item_t it;
      @(negedge clk);
      tick = 1'b1;
      it.req = req;
      it.exp = 1'b0;
      if (msel != 2'b11) begin
         mcnt++;
         if (mcnt == per_of(msel)) begin
            it.exp = 1'b1;
            mcnt = 0;
         end
      end
      q.push_back(it);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic ticks(int n, string req);
      for (int i = 0; i < n; i++) tick_once(req);
   endtask

   task automatic pins(logic s, logic d);
      @(negedge clk);
      scl = s;
      sda = d;
      repeat (4) @(negedge clk);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   // start then stop: a valid restart (R3)
   task automatic kick();
      pins(1, 0);
      pins(0, 0);
      pins(1, 0);
      pins(1, 1);
      settle();
      mcnt = 0;
   endtask

   task automatic set_sel(logic [1:0] v, logic w);
      @(negedge clk);
      wp = w;
      @(negedge clk);
      sel = v;
      repeat (3) @(negedge clk);
      if (!w && v != msel) begin
         msel = v;
         mcnt = 0;
      end
      sel = msel;
      repeat (2) @(negedge clk);
      wp = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (to !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: timeout during reset, actual %0b expected 0", to);
      end
      arst_n = 1'b1;
      repeat (3) @(negedge clk);
      n_chk++;
      if (to !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: timeout after reset, actual %0b expected 0", to);
      end
      run = 1'b1;

      ticks(P0, "R10");            // count starts at zero
      ticks(2 * P0, "R7");         // periodic pulses

      ticks(10, "R3");
      kick();
      ticks(P0, "R3");

      ticks(10, "R5");
      pins(0, 1);                  // SDA moves only while SCL low
      pins(0, 0);
      pins(1, 0);
      pins(1, 1);                  // stop with nothing pending
      settle();
      ticks(P0, "R5");

      ticks(5, "R4");
      pins(1, 0);                  // start only
      pins(0, 0);
      pins(0, 1);
      pins(1, 1);                  // back to idle, no stop
      settle();
      ticks(P0, "R4");

      ticks(5, "R6");
      pins(1, 0);                  // first start
      pins(0, 0);
      pins(0, 1);
      pins(1, 1);
      pins(1, 0);                  // second start
      pins(0, 0);
      pins(1, 0);
      pins(1, 1);                  // stop
      settle();
      mcnt = 0;
      ticks(P0, "R6");

      set_sel(2'b01, 1'b0);
      ticks(P1, "R1");
      set_sel(2'b10, 1'b0);
      ticks(P2 + 5, "R1");

      ticks(50, "R9");
      set_sel(2'b00, 1'b0);
      ticks(P0, "R9");

      ticks(10, "R8");
      set_sel(2'b10, 1'b1);
      ticks(P0, "R8");

      set_sel(2'b11, 1'b0);
      ticks(3 * P2, "R2");
      set_sel(2'b00, 1'b0);
      ticks(P0, "R2");

      ticks(7, "R11");
      repeat (300) @(negedge clk);
      ticks(P0, "R11");

      repeat (4) @(negedge clk);
      run = 1'b0;
      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R11: %0d expected pulses unchecked, expected 0", q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R11: watchdog expired, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule